// File: doc/BRIEF.md
# HDLC Serial Transmit Framer with Zero Insertion and Frame Check

This block is the serial transmit side of an HDLC link. A controller issues a
short sequence of commands (send a flag, send payload, send the check sequence,
send a closing flag), and the block turns each command into a stream of single
bits. One bit leaves per bit-slot enable. Payload arrives a byte at a time over a
ready/valid port. The last byte is marked, and that mark ends the payload command.

Over the payload the block accumulates a frame check sequence. Its width (16 or
32 bits) and starting value (all ones or all zeros) come from a small
configuration register. On the check command, the complemented register is sent
least significant bit first. When zero insertion is enabled, a zero is placed on
the line after every run of five ones in the payload and check portions. Flags
(0x7E, sent LSB first) are never altered and do not advance the run count. When
the block has no bit to send in a slot, because it is idle or waiting for a byte,
the bit strobe stays low for that slot.

Top module: `hdlc_tx_framer`

## Requirements
- R1: After reset, cmd_ready is 1, tx_vld and in_ready are 0, and the configuration register is all zeros: zero preset, 16-bit check, zero insertion off.
- R2: Command code 0 sends the flag 0x7E LSB first (0,1,1,1,1,1,1,0) with no inserted zero, even when insertion is enabled. It also reloads the check register with its preset.
- R3: Command code 1 sends payload bytes taken from in_data when in_valid and in_ready are both high, each byte LSB first, ending after the byte that carried in_last.
- R4: Command code 2 with configuration bit 1 clear sends 16 bits of the complemented reflected CRC (polynomial x^16+x^12+x^5+1), LSB first. For payload "123456789" with ones preset, the value sent is 0x906E.
- R5: Command code 2 with configuration bit 1 set sends 32 bits of the complemented reflected IEEE 802.3 CRC, LSB first. For "123456789" with ones preset, the value sent is 0xCBF43926.
- R6: Configuration bit 2 selects the preset: 1 gives all ones, 0 gives all zeros. With zero preset, the 16-bit check of "123456789" is 0xDE76.
- R7: With configuration bit 0 set, a 0 is sent after every five consecutive 1s in the payload and check portions. The run count restarts on every 0 sent, including an inserted one. Inserted zeros do not enter the CRC.
- R8: With configuration bit 0 clear, no zero is ever inserted. A frame is exactly 8 + 8*bytes + check width + 8 bits long.
- R9: tx_vld pulses only in the cycle after a bit_en. No bit is sent while idle. A missing byte or a sparse bit_en only delays the stream and never loses or changes bits.
- R10: cmd_ready is low from the cycle after a command is accepted until that command ends. Command code 3 is accepted and has no effect. A write of cfg_wdata with cfg_wr loads the configuration register.
- R11: The check register does not advance while flags or check bits are sent. A second check command without a new flag resends the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Bit-slot enable |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 3 | bit0 insertion enable, bit1 32-bit check, bit2 ones preset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 0 flag, 1 payload, 2 check, 3 no-op |
| cmd_ready | output | 1 | Command accepted this cycle when valid |
| in_valid | input | 1 | Payload byte present |
| in_data | input | BYTE_W | Payload byte |
| in_last | input | 1 | Marks the final payload byte |
| in_ready | output | 1 | Payload byte taken when valid |
| tx_bit | output | 1 | Serial line bit |
| tx_vld | output | 1 | tx_bit holds a new bit this cycle |

## Verification
The ASCII string "123456789" is sent under each preset and check width. This ties the emitted check to published check values and separates a wrong polynomial, a wrong preset, a missing complement and a wrong bit order. Payloads full of 0xFF, 0x7E, 0xF8 and 0x1F are sent with insertion on and then off. The on case shows whether runs that cross byte boundaries and the payload-to-check boundary are broken up. The off case shows whether any zero is inserted when it should not be. Sparse bit enables combined with gaps between bytes show whether a stall drops or repeats bits, and a repeated check command shows whether the register advances during shift-out.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_FLAG = 2'd1,
      ST_DATA = 2'd2,
      ST_CRC  = 2'd3
   } tx_state_e;

   localparam logic [1:0] OP_FLAG = 2'd0;
   localparam logic [1:0] OP_DATA = 2'd1;
   localparam logic [1:0] OP_CRC  = 2'd2;
   localparam logic [1:0] OP_NOP  = 2'd3;

   localparam int CFG_STUFF = 0;
   localparam int CFG_WIDE  = 1;
   localparam int CFG_ONES  = 2;
   localparam int CFG_W     = 3;

   localparam int          FLAG_W   = 8;
   localparam logic [7:0]  FLAG_PAT = 8'h7E;

   localparam logic [31:0] POLY16_REFL = 32'h0000_8408;
   localparam logic [31:0] POLY32_REFL = 32'hEDB8_8320;

endpackage

// File: rtl/hdlc_crc_unit.sv
module hdlc_crc_unit #(
   parameter int          CRC_W  = 32,
   parameter int          NARROW = 16,
   parameter logic [31:0] POLY_N = 32'h0000_8408,
   parameter logic [31:0] POLY_W = 32'hEDB8_8320
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             advance,
   input  logic             din,
   input  logic             wide,
   input  logic             ones,
   output logic [CRC_W-1:0] crc
);

   if (CRC_W != 32) begin : g_bad_w
      $error("hdlc_crc_unit: CRC_W must be 32");
   end
   if (NARROW < 1 || NARROW >= CRC_W) begin : g_bad_n
      $error("hdlc_crc_unit: NARROW out of range");
   end

   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] preset;
   logic [CRC_W-1:0] poly;
   logic             fb;

   for (genvar g = 0; g < CRC_W; g++) begin : g_preset
      if (g < NARROW) begin : g_lo
         assign preset[g] = ones;
      end else begin : g_hi
         assign preset[g] = ones & wide;
      end
   end

   assign poly = wide ? POLY_W : POLY_N;
   assign fb   = crc_q[0] ^ din;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q <= '0;
      end else if (load) begin
         crc_q <= preset;
      end else if (advance) begin
         crc_q <= {1'b0, crc_q[CRC_W-1:1]} ^ (fb ? poly : '0);
      end
   end

   assign crc = crc_q;

   // R11
   crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !advance) |=> $stable(crc_q));

endmodule

// File: rtl/hdlc_zero_stuffer.sv
module hdlc_zero_stuffer #(
   parameter int RUN_LEN = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic strobe,
   input  logic bit_in,
   input  logic count_en,
   input  logic stuff_en,
   output logic stuff_pend
);

   if (RUN_LEN < 1) begin : g_bad_run
      $error("hdlc_zero_stuffer: RUN_LEN must be at least 1");
   end

   localparam int RUN_W = $clog2(RUN_LEN + 1);
   localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(RUN_LEN);

   logic [RUN_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear) begin
         cnt_q <= '0;
      end else if (strobe && count_en) begin
         if (!bit_in) begin
            cnt_q <= '0;
         end else if (cnt_q != RUN_MAX) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign stuff_pend = stuff_en && count_en && (cnt_q == RUN_MAX);

   // R7
   run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= RUN_MAX);

   // R7
   run_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && count_en && !bit_in && !clear) |=> (cnt_q == '0));

endmodule

// File: rtl/hdlc_tx_shifter.sv
module hdlc_tx_shifter #(
   parameter int SH_W  = 32,
   parameter int LEN_W = $clog2(SH_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [SH_W-1:0]  load_val,
   input  logic [LEN_W-1:0] load_len,
   input  logic             shift,
   output logic             head,
   output logic             empty
);

   if (SH_W < 2) begin : g_bad_sh
      $error("hdlc_tx_shifter: SH_W too small");
   end

   logic [SH_W-1:0]  sh_q;
   logic [LEN_W-1:0] len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         len_q <= '0;
      end else if (load) begin
         sh_q  <= load_val;
         len_q <= load_len;
      end else if (shift) begin
         sh_q  <= {1'b0, sh_q[SH_W-1:1]};
         len_q <= len_q - 1'b1;
      end
   end

   assign head  = sh_q[0];
   assign empty = (len_q == '0);

   // R9
   no_shift_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shift |-> !empty);

   // R3
   load_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> empty);

endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
   import hdlc_tx_pkg::*;
#(
   parameter int BYTE_W  = 8,
   parameter int RUN_LEN = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              cfg_wr,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   output logic              cmd_ready,
   input  logic              in_valid,
   input  logic [BYTE_W-1:0] in_data,
   input  logic              in_last,
   output logic              in_ready,
   output logic              tx_bit,
   output logic              tx_vld
);

   localparam int SH_W   = 32;
   localparam int NARROW = 16;
   localparam int LEN_W  = $clog2(SH_W + 1);

   if (BYTE_W < 1 || BYTE_W > SH_W) begin : g_bad_byte
      $error("hdlc_tx_framer: BYTE_W out of range");
   end

   tx_state_e        state_q;
   logic             last_seen_q;
   logic [CFG_W-1:0] cfg_q;
   logic             tx_bit_q, tx_vld_q;

   logic             accept, byte_take, done;
   logic             sh_head, sh_empty, sh_load, sh_shift;
   logic [SH_W-1:0]  sh_val;
   logic [LEN_W-1:0] sh_len;
   logic [SH_W-1:0]  crc;
   logic             stuff_pend, emit_stuff, emit_sh, counted;

   // configuration register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q <= '0;
      else if (cfg_wr) cfg_q <= cfg_wdata;
   end

   assign cmd_ready = (state_q == ST_IDLE);
   assign accept    = cmd_valid && cmd_ready;
   assign in_ready  = (state_q == ST_DATA) && sh_empty && !last_seen_q;
   assign byte_take = in_valid && in_ready;
   assign counted   = (state_q == ST_DATA) || (state_q == ST_CRC);

   assign emit_stuff = bit_en && stuff_pend;
   assign emit_sh    = bit_en && !stuff_pend && !sh_empty && (state_q != ST_IDLE);
   assign sh_shift   = emit_sh;

   assign done = (state_q != ST_IDLE) && sh_empty && !stuff_pend &&
                 ((state_q != ST_DATA) || last_seen_q);

   // shifter load selection
   always_comb begin
      sh_load = 1'b0;
      sh_val  = '0;
      sh_len  = '0;
      if (accept && cmd_op == OP_FLAG) begin
         sh_load = 1'b1;
         sh_val  = SH_W'(FLAG_PAT);
         sh_len  = LEN_W'(FLAG_W);
      end else if (accept && cmd_op == OP_CRC) begin
         sh_load = 1'b1;
         sh_val  = ~crc;
         sh_len  = cfg_q[CFG_WIDE] ? LEN_W'(SH_W) : LEN_W'(NARROW);
      end else if (byte_take) begin
         sh_load = 1'b1;
         sh_val  = SH_W'(in_data);
         sh_len  = LEN_W'(BYTE_W);
      end
   end

   // command sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         last_seen_q <= 1'b0;
      end else begin
         if (accept) begin
            case (cmd_op)
               OP_FLAG: state_q <= ST_FLAG;
               OP_DATA: state_q <= ST_DATA;
               OP_CRC:  state_q <= ST_CRC;
               default: state_q <= ST_IDLE;
            endcase
            last_seen_q <= 1'b0;
         end else if (done) begin
            state_q <= ST_IDLE;
         end
         if (byte_take) last_seen_q <= in_last;
      end
   end

   // output register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_bit_q <= 1'b1;
         tx_vld_q <= 1'b0;
      end else begin
         tx_vld_q <= emit_stuff || emit_sh;
         if (emit_stuff)   tx_bit_q <= 1'b0;
         else if (emit_sh) tx_bit_q <= sh_head;
      end
   end

   assign tx_bit = tx_bit_q;
   assign tx_vld = tx_vld_q;

   hdlc_tx_shifter #(.SH_W(SH_W), .LEN_W(LEN_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (sh_load),
      .load_val (sh_val),
      .load_len (sh_len),
      .shift    (sh_shift),
      .head     (sh_head),
      .empty    (sh_empty)
   );

   hdlc_crc_unit #(
      .CRC_W (SH_W),
      .NARROW(NARROW),
      .POLY_N(POLY16_REFL),
      .POLY_W(POLY32_REFL)
   ) u_crc (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept && cmd_op == OP_FLAG),
      .advance (emit_sh && state_q == ST_DATA),
      .din     (sh_head),
      .wide    (cfg_q[CFG_WIDE]),
      .ones    (cfg_q[CFG_ONES]),
      .crc     (crc)
   );

   hdlc_zero_stuffer #(.RUN_LEN(RUN_LEN)) u_stuff (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (accept && cmd_op == OP_FLAG),
      .strobe     (emit_stuff || emit_sh),
      .bit_in     (emit_sh ? sh_head : 1'b0),
      .count_en   (counted),
      .stuff_en   (cfg_q[CFG_STUFF]),
      .stuff_pend (stuff_pend)
   );

   // R7
   stuff_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      emit_stuff |=> (tx_vld && !tx_bit));

   // R9
   strobe_follows_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_vld |-> $past(bit_en));

   // R9
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE) |=> !tx_vld);

   // R10
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready && cmd_op != OP_NOP) |=> !cmd_ready);

   // R2
   flag_unstuffed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FLAG && bit_en) |-> !emit_stuff);

endmodule

// File: tb/hdlc_tx_framer_test.sv
`timescale 1ns/1ps
module hdlc_tx_framer_test;
   import hdlc_tx_pkg::*;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_en = 1'b0;
   logic       cfg_wr = 1'b0;
   logic [2:0] cfg_wdata = '0;
   logic       cmd_valid = 1'b0;
   logic [1:0] cmd_op = '0;
   logic       cmd_ready;
   logic       in_valid = 1'b0;
   logic [7:0] in_data = '0;
   logic       in_last = 1'b0;
   logic       in_ready;
   logic       tx_bit, tx_vld;

   int checks = 0, fails = 0;
   int en_period = 1;
   int cap_n = 0;
   bit cap [0:1023];
   int exp_n = 0;
   bit expb [0:1023];
   int run_m = 0;
   logic [31:0] crc_m = '0;
   bit m_stuff = 0, m_wide = 0, m_ones = 0;
   logic [7:0] frm [0:15];

   always #10 clk = ~clk;

   hdlc_tx_framer uut (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
      .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ready(cmd_ready),
      .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
      .tx_bit(tx_bit), .tx_vld(tx_vld)
   );

   initial begin
      int en_cnt = 0;
      forever begin
         @(negedge clk);
         en_cnt++;
         if (en_cnt >= en_period) begin bit_en = 1'b1; en_cnt = 0; end
         else bit_en = 1'b0;
      end
   end

   initial begin
      forever begin
         @(negedge clk);
         if (tx_vld && cap_n < 1024) begin cap[cap_n] = tx_bit; cap_n++; end
      end
   end

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      summary();
   end

   task automatic check(input bit ok, input string tag, input longint act, input longint expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
      end
   endtask

   // ---------------- reference model ----------------
   task automatic m_push(input bit b, input bit counted);
      expb[exp_n] = b; exp_n++;
      if (counted) begin
         if (b) run_m++; else run_m = 0;
         if (m_stuff && run_m == 5) begin expb[exp_n] = 1'b0; exp_n++; run_m = 0; end
      end
   endtask

   task automatic m_flag();
      run_m = 0;
      crc_m = m_ones ? (m_wide ? 32'hFFFF_FFFF : 32'h0000_FFFF) : 32'h0;
      for (int i = 0; i < 8; i++) m_push(FLAG_PAT[i], 1'b0);
   endtask

   task automatic m_byte(input logic [7:0] b);
      for (int i = 0; i < 8; i++) begin
         bit fb;
         m_push(b[i], 1'b1);
         fb = crc_m[0] ^ b[i];
         crc_m = crc_m >> 1;
         if (fb) crc_m = crc_m ^ (m_wide ? 32'hEDB8_8320 : 32'h0000_8408);
      end
   endtask

   task automatic m_crc();
      logic [31:0] v = ~crc_m;
      for (int i = 0; i < (m_wide ? 32 : 16); i++) m_push(v[i], 1'b1);
   endtask

   function automatic logic [31:0] cap_val(input int start, input int w);
      logic [31:0] v = '0;
      for (int i = 0; i < w; i++) v[i] = cap[start + i];
      return v;
   endfunction

   // ---------------- drivers ----------------
   task automatic set_cfg(input bit st, input bit wd, input bit on);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_wdata = {on, wd, st};
      @(negedge clk);
      cfg_wr = 1'b0;
      m_stuff = st; m_wide = wd; m_ones = on;
   endtask

   task automatic do_cmd(input logic [1:0] op);
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic feed(input logic [7:0] b, input bit last, input int gap);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1; in_data = b; in_last = last;
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
      repeat (gap) @(negedge clk);
   endtask

   task automatic run_frame(input int n, input int gap, input bit two_crc);
      cap_n = 0; exp_n = 0;
      do_cmd(OP_FLAG);
      check(cmd_ready == 1'b0, "R10 busy after accept", cmd_ready, 0);
      m_flag();
      do_cmd(OP_DATA);
      for (int k = 0; k < n; k++) begin
         feed(frm[k], k == n - 1, gap);
         m_byte(frm[k]);
      end
      do_cmd(OP_CRC); m_crc();
      if (two_crc) begin do_cmd(OP_CRC); m_crc(); end
      do_cmd(OP_FLAG); m_flag();
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      repeat (4 * en_period + 4) @(negedge clk);
   endtask

   task automatic cmp_stream(input string tag);
      int bad = -1;
      check(cap_n == exp_n, {tag, " length"}, cap_n, exp_n);
      for (int i = 0; i < exp_n && i < cap_n; i++)
         if (bad < 0 && cap[i] != expb[i]) bad = i;
      check(bad < 0, {tag, " first bit mismatch index"}, bad, -1);
   endtask

   task automatic load_check_string();
      for (int k = 0; k < 9; k++) frm[k] = 8'h31 + 8'(k);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      check(cmd_ready == 1'b1, "R1 cmd_ready after reset", cmd_ready, 1);
      check(tx_vld == 1'b0, "R1 tx_vld after reset", tx_vld, 0);
      check(in_ready == 1'b0, "R1 in_ready after reset", in_ready, 0);
      cap_n = 0;
      repeat (20) @(negedge clk);
      check(cap_n == 0, "R9 no bits while idle", cap_n, 0);
      do_cmd(OP_NOP);
      repeat (10) @(negedge clk);
      check(cap_n == 0 && cmd_ready, "R10 no-op command has no effect", cap_n, 0);
   endtask

   task automatic t_default_cfg();
      load_check_string();
      run_frame(9, 0, 0);
      cmp_stream("R1 default frame");
      check(cap_val(0, 8) == 32'h7E, "R2 opening flag", cap_val(0, 8), 32'h7E);
      check(cap_val(8, 8) == 32'h31, "R3 first byte LSB first", cap_val(8, 8), 32'h31);
      check(cap_val(80, 16) == 32'hDE76, "R6 zero preset crc16", cap_val(80, 16), 32'hDE76);
      check(cap_n == 104, "R8 frame length no insertion", cap_n, 104);
   endtask

   task automatic t_crc16_ones();
      set_cfg(0, 0, 1);
      load_check_string();
      run_frame(9, 0, 0);
      cmp_stream("R4 crc16 frame");
      check(cap_val(80, 16) == 32'h906E, "R4 crc16 check value", cap_val(80, 16), 32'h906E);
   endtask

   task automatic t_crc32();
      set_cfg(0, 1, 1);
      load_check_string();
      run_frame(9, 0, 0);
      cmp_stream("R5 crc32 frame");
      check(cap_val(80, 32) == 32'hCBF4_3926, "R5 crc32 check value", cap_val(80, 32), 32'hCBF4_3926);
      check(cap_n == 120, "R5 crc32 frame length", cap_n, 120);
   endtask

   task automatic load_ones_data();
      frm[0] = 8'hFF; frm[1] = 8'hFF; frm[2] = 8'h7E; frm[3] = 8'hF8; frm[4] = 8'h1F;
   endtask

   task automatic t_stuff_on();
      set_cfg(1, 0, 1);
      load_ones_data();
      run_frame(5, 0, 0);
      cmp_stream("R7 insertion frame");
      check(cap_n > 72, "R7 inserted zeros lengthen frame", cap_n, 72);
      check(cap_val(0, 8) == 32'h7E, "R2 opening flag unaltered", cap_val(0, 8), 32'h7E);
      check(cap_val(cap_n - 8, 8) == 32'h7E, "R2 closing flag unaltered",
            cap_val(cap_n - 8, 8), 32'h7E);
   endtask

   task automatic t_stuff_off();
      set_cfg(0, 0, 1);
      load_ones_data();
      run_frame(5, 0, 0);
      cmp_stream("R8 no insertion frame");
      check(cap_n == 72, "R8 exact length", cap_n, 72);
   endtask

   task automatic t_sparse();
      set_cfg(1, 1, 1);
      load_ones_data();
      frm[5] = 8'h00; frm[6] = 8'hFC;
      en_period = 3;
      run_frame(7, 5, 0);
      cmp_stream("R9 sparse enable with byte gaps");
      en_period = 1;
   endtask

   task automatic t_double_crc();
      set_cfg(0, 0, 1);
      load_check_string();
      run_frame(9, 0, 1);
      cmp_stream("R11 repeated check frame");
      check(cap_val(96, 16) == cap_val(80, 16), "R11 second check equals first",
            cap_val(96, 16), cap_val(80, 16));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_default_cfg();
      t_crc16_ones();
      t_crc32();
      t_stuff_on();
      t_stuff_off();
      t_sparse();
      t_double_crc();
      summary();
   end

endmodule